// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Gate

This block decides, every cycle, how many of the two oldest decoded instructions an in-order superscalar core sends into its execution pipes. Each candidate slot carries a valid bit, an operation class, a destination register with a write flag, and two source register numbers. The block answers with two issue enables and a pipe code for each slot. The surrounding decode queue pops the slots that issued. The older candidate always sits in slot 0 and the younger in slot 1.

Four execution pipes exist: two ALU pipes, one load/store pipe and one multiply pipe. Either slot may be steered to the load/store pipe. A scoreboard keeps one down-counter per architectural register. The counter is loaded when a writing instruction issues and counts the cycles until its result can be bypassed. An instruction is held back while any register it reads or writes is still counting. A flush input clears every counter and blocks issue in that cycle.

Top module: `dual_issue_ctl`

## Requirements
- R1: After reset no register is pending, so a valid slot-0 instruction issues in the first cycle whatever registers it names.
- R2: Issue stays in program order. Slot 1 issues only in a cycle where slot 0 also issues. A slot with its valid bit low never issues.
- R3: Class encoding is ALU=0, load/store=1, multiply=2, and 3 behaves as ALU. The result latencies are 1, 3 and 4 cycles. A writer that issues in cycle t blocks readers of its destination until cycle t+latency, and a reader that is otherwise free issues in exactly that cycle.
- R4: An instruction whose destination register is still pending does not issue. This write-after-write stall is released on the same cycle count as R3.
- R5: Slot 1 is held when slot 0 writes a register other than 15 and slot 1 reads that register as either source or also writes it.
- R6: When both slots need the load/store pipe, or both need the multiply pipe, only slot 0 issues. Two ALU-class instructions may issue together.
- R7: Pipe codes are ALU0=0, ALU1=1, load/store=2, multiply=3. An ALU-class slot 0 goes to code 0. An ALU-class slot 1 goes to code 1 when slot 0 is also ALU-class and to code 0 otherwise. Load/store and multiply classes map to codes 2 and 3 from either slot. A slot that does not issue shows code 0.
- R8: Register 15 is never pending. Writes to it set nothing, reads of it never stall, and it never creates a pair dependency.
- R9: While flush is high neither slot issues, and in the cycle after a flush no register is pending.
- R10: An instruction with its write flag low (a store) marks no register pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clears all pending registers and blocks issue this cycle |
| s0_vld_i | input | 1 | Older candidate present |
| s0_cls_i | input | 2 | Older candidate operation class |
| s0_wr_i | input | 1 | Older candidate writes its destination |
| s0_dst_i | input | 4 | Older candidate destination register |
| s0_srca_i | input | 4 | Older candidate first source register |
| s0_srcb_i | input | 4 | Older candidate second source register |
| s1_vld_i | input | 1 | Younger candidate present |
| s1_cls_i | input | 2 | Younger candidate operation class |
| s1_wr_i | input | 1 | Younger candidate writes its destination |
| s1_dst_i | input | 4 | Younger candidate destination register |
| s1_srca_i | input | 4 | Younger candidate first source register |
| s1_srcb_i | input | 4 | Younger candidate second source register |
| iss0_o | output | 1 | Older candidate issues this cycle |
| iss1_o | output | 1 | Younger candidate issues this cycle |
| pipe0_o | output | 2 | Pipe code for the older candidate |
| pipe1_o | output | 2 | Pipe code for the younger candidate |

## Verification
The bench builds the block with its default values: 16 registers and latencies of 1, 3 and 4. It keeps operands among registers 0 to 3 and 15 so that source, write-after-write and pair hazards occur in most cycles. With these latencies the release cycle of each class can be measured exactly. A sweep covers every pair of the four class codes against five register relations on a clean scoreboard. A long pseudo-random run with occasional flushes is then compared against a ready-time model that records, for each register, the cycle in which it becomes usable.

// File: rtl/dic_pkg.sv
package dic_pkg;

  typedef enum logic [1:0] {
    CLS_ALU = 2'd0,
    CLS_LSU = 2'd1,
    CLS_MUL = 2'd2,
    CLS_RSV = 2'd3
  } op_cls_e;

  typedef enum logic [1:0] {
    PIPE_ALU0 = 2'd0,
    PIPE_ALU1 = 2'd1,
    PIPE_LSU  = 2'd2,
    PIPE_MUL  = 2'd3
  } pipe_e;

  // Class that owns a pipe with only one instance
  function automatic logic needs_single_pipe(input logic [1:0] cls);
    return (cls == CLS_LSU) || (cls == CLS_MUL);
  endfunction

  // Both candidates want the same lone pipe
  function automatic logic pair_clash(input logic [1:0] cls0, input logic [1:0] cls1);
    return needs_single_pipe(cls0) && (cls0 == cls1);
  endfunction

  function automatic logic [1:0] older_pipe(input logic [1:0] cls);
    case (cls)
      CLS_LSU: return PIPE_LSU;
      CLS_MUL: return PIPE_MUL;
      default: return PIPE_ALU0;
    endcase
  endfunction

  // ALU slot 1 moves to the second ALU only if slot 0 occupies the first
  function automatic logic [1:0] younger_pipe(input logic [1:0] cls0, input logic [1:0] cls1);
    if (needs_single_pipe(cls1)) return older_pipe(cls1);
    if (needs_single_pipe(cls0)) return PIPE_ALU0;
    return PIPE_ALU1;
  endfunction

endpackage

// File: rtl/dic_scoreboard.sv
module dic_scoreboard
  import dic_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int LAT_ALU = 1,
  parameter int LAT_LSU = 3,
  parameter int LAT_MUL = 4,
  localparam int RW     = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic            set0_en_i,
  input  logic [RW-1:0]   set0_reg_i,
  input  logic [1:0]      set0_cls_i,
  input  logic            set1_en_i,
  input  logic [RW-1:0]   set1_reg_i,
  input  logic [1:0]      set1_cls_i,
  output logic [NREG-1:0] pend_o
);

  localparam int LMAX = (LAT_ALU > LAT_LSU)
                        ? ((LAT_ALU > LAT_MUL) ? LAT_ALU : LAT_MUL)
                        : ((LAT_LSU > LAT_MUL) ? LAT_LSU : LAT_MUL);
  localparam int CW   = $clog2(LMAX + 1);

  // Cycles a fresh result stays unusable after its producer issues
  function automatic logic [CW-1:0] hold_cycles(input logic [1:0] cls);
    case (cls)
      CLS_LSU: return CW'(LAT_LSU - 1);
      CLS_MUL: return CW'(LAT_MUL - 1);
      default: return CW'(LAT_ALU - 1);
    endcase
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == NREG - 1) begin : g_free
      assign pend_o[r] = 1'b0;
    end else begin : g_cnt
      localparam logic [RW-1:0] IDX = RW'(r);
      logic [CW-1:0] cnt_q;
      logic          hit0_w;
      logic          hit1_w;

      assign hit0_w = set0_en_i && (set0_reg_i == IDX);
      assign hit1_w = set1_en_i && (set1_reg_i == IDX);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (flush_i)      cnt_q <= '0;
        else if (hit0_w)       cnt_q <= hold_cycles(set0_cls_i);
        else if (hit1_w)       cnt_q <= hold_cycles(set1_cls_i);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
      end

      assign pend_o[r] = (cnt_q != '0);
    end
  end

endmodule

// File: rtl/dic_hazard.sv
module dic_hazard
  import dic_pkg::*;
#(
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [NREG-1:0] pend_i,
  input  logic            flush_i,
  input  logic            vld0_i,
  input  logic [1:0]      cls0_i,
  input  logic            wr0_i,
  input  logic [RW-1:0]   dst0_i,
  input  logic [RW-1:0]   srca0_i,
  input  logic [RW-1:0]   srcb0_i,
  input  logic            vld1_i,
  input  logic [1:0]      cls1_i,
  input  logic            wr1_i,
  input  logic [RW-1:0]   dst1_i,
  input  logic [RW-1:0]   srca1_i,
  input  logic [RW-1:0]   srcb1_i,
  output logic            iss0_o,
  output logic            iss1_o
);

  localparam logic [RW-1:0] FREE = RW'(NREG - 1);

  function automatic logic reg_busy(input logic [NREG-1:0] pv, input logic [RW-1:0] r);
    return (r != FREE) && pv[r];
  endfunction

  function automatic logic slot_ready(input logic [NREG-1:0] pv, input logic wr,
                                      input logic [RW-1:0] d, input logic [RW-1:0] a,
                                      input logic [RW-1:0] b);
    return !reg_busy(pv, a) && !reg_busy(pv, b) && !(wr && reg_busy(pv, d));
  endfunction

  // Younger touches the older one's fresh destination
  function automatic logic touches(input logic wr_o, input logic [RW-1:0] d_o,
                                   input logic wr_y, input logic [RW-1:0] d_y,
                                   input logic [RW-1:0] a_y, input logic [RW-1:0] b_y);
    return wr_o && (d_o != FREE) && ((a_y == d_o) || (b_y == d_o) || (wr_y && (d_y == d_o)));
  endfunction

  logic rdy0_w, rdy1_w, pair_dep_w, clash_w;

  assign rdy0_w     = slot_ready(pend_i, wr0_i, dst0_i, srca0_i, srcb0_i);
  assign rdy1_w     = slot_ready(pend_i, wr1_i, dst1_i, srca1_i, srcb1_i);
  assign pair_dep_w = touches(wr0_i, dst0_i, wr1_i, dst1_i, srca1_i, srcb1_i);
  assign clash_w    = pair_clash(cls0_i, cls1_i);

  assign iss0_o = vld0_i && rdy0_w && !flush_i;
  assign iss1_o = iss0_o && vld1_i && rdy1_w && !pair_dep_w && !clash_w;

endmodule

// File: rtl/dic_steer.sv
module dic_steer
  import dic_pkg::*;
(
  input  logic [1:0] cls0_i,
  input  logic [1:0] cls1_i,
  input  logic       iss0_i,
  input  logic       iss1_i,
  output logic [1:0] pipe0_o,
  output logic [1:0] pipe1_o
);

  assign pipe0_o = iss0_i ? older_pipe(cls0_i) : PIPE_ALU0;
  assign pipe1_o = iss1_i ? younger_pipe(cls0_i, cls1_i) : PIPE_ALU0;

endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dic_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int LAT_ALU = 1,
  parameter int LAT_LSU = 3,
  parameter int LAT_MUL = 4,
  localparam int RW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          s0_vld_i,
  input  logic [1:0]    s0_cls_i,
  input  logic          s0_wr_i,
  input  logic [RW-1:0] s0_dst_i,
  input  logic [RW-1:0] s0_srca_i,
  input  logic [RW-1:0] s0_srcb_i,
  input  logic          s1_vld_i,
  input  logic [1:0]    s1_cls_i,
  input  logic          s1_wr_i,
  input  logic [RW-1:0] s1_dst_i,
  input  logic [RW-1:0] s1_srca_i,
  input  logic [RW-1:0] s1_srcb_i,
  output logic          iss0_o,
  output logic          iss1_o,
  output logic [1:0]    pipe0_o,
  output logic [1:0]    pipe1_o
);

  logic [NREG-1:0] pend_w;
  logic            set0_en_w;
  logic            set1_en_w;

  assign set0_en_w = iss0_o && s0_wr_i;
  assign set1_en_w = iss1_o && s1_wr_i;

  dic_scoreboard #(
    .NREG(NREG), .LAT_ALU(LAT_ALU), .LAT_LSU(LAT_LSU), .LAT_MUL(LAT_MUL)
  ) i_sb (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .set0_en_i  (set0_en_w),
    .set0_reg_i (s0_dst_i),
    .set0_cls_i (s0_cls_i),
    .set1_en_i  (set1_en_w),
    .set1_reg_i (s1_dst_i),
    .set1_cls_i (s1_cls_i),
    .pend_o     (pend_w)
  );

  dic_hazard #(.NREG(NREG)) i_hz (
    .pend_i  (pend_w),
    .flush_i (flush_i),
    .vld0_i  (s0_vld_i),
    .cls0_i  (s0_cls_i),
    .wr0_i   (s0_wr_i),
    .dst0_i  (s0_dst_i),
    .srca0_i (s0_srca_i),
    .srcb0_i (s0_srcb_i),
    .vld1_i  (s1_vld_i),
    .cls1_i  (s1_cls_i),
    .wr1_i   (s1_wr_i),
    .dst1_i  (s1_dst_i),
    .srca1_i (s1_srca_i),
    .srcb1_i (s1_srcb_i),
    .iss0_o  (iss0_o),
    .iss1_o  (iss1_o)
  );

  dic_steer i_st (
    .cls0_i  (s0_cls_i),
    .cls1_i  (s1_cls_i),
    .iss0_i  (iss0_o),
    .iss1_i  (iss1_o),
    .pipe0_o (pipe0_o),
    .pipe1_o (pipe1_o)
  );

endmodule

// File: rtl/dic_checker.sv
module dic_checker
  import dic_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int LAT_LSU = 3,
  localparam int RW     = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush_i,
  input logic            s0_vld_i,
  input logic [1:0]      s0_cls_i,
  input logic            s0_wr_i,
  input logic [RW-1:0]   s0_dst_i,
  input logic [RW-1:0]   s0_srca_i,
  input logic [RW-1:0]   s0_srcb_i,
  input logic            s1_vld_i,
  input logic [1:0]      s1_cls_i,
  input logic            s1_wr_i,
  input logic [RW-1:0]   s1_dst_i,
  input logic [RW-1:0]   s1_srca_i,
  input logic [RW-1:0]   s1_srcb_i,
  input logic            iss0_o,
  input logic            iss1_o,
  input logic [1:0]      pipe0_o,
  input logic [1:0]      pipe1_o,
  input logic [NREG-1:0] pend_w
);

  localparam logic [RW-1:0] FREE = RW'(NREG - 1);

  assert_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_o |-> (iss0_o && s1_vld_i && s0_vld_i));

  assert_src_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss0_o |-> (!pend_w[s0_srca_i] && !pend_w[s0_srcb_i]));

  assert_waw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1_o && s1_wr_i) |-> !pend_w[s1_dst_i]);

  assert_pair_dep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1_o && s0_wr_i && (s0_dst_i != FREE)) |->
      ((s1_srca_i != s0_dst_i) && (s1_srcb_i != s0_dst_i) && !(s1_wr_i && (s1_dst_i == s0_dst_i))));

  assert_lone_pipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_o |-> !((s0_cls_i == s1_cls_i) && ((s0_cls_i == CLS_LSU) || (s0_cls_i == CLS_MUL))));

  assert_pipes_differ_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0_o && iss1_o) |-> (pipe0_o != pipe1_o));

  assert_free_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_w[FREE]);

  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> (!iss0_o && !iss1_o));

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (pend_w == '0));

  if (LAT_LSU > 1) begin : g_ld
    assert_load_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss0_o && s0_wr_i && (s0_cls_i == CLS_LSU) && (s0_dst_i != FREE)) |=> pend_w[$past(s0_dst_i)]);
  end

endmodule

bind dual_issue_ctl dic_checker #(.NREG(NREG), .LAT_LSU(LAT_LSU)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_i   (flush_i),
  .s0_vld_i  (s0_vld_i),
  .s0_cls_i  (s0_cls_i),
  .s0_wr_i   (s0_wr_i),
  .s0_dst_i  (s0_dst_i),
  .s0_srca_i (s0_srca_i),
  .s0_srcb_i (s0_srcb_i),
  .s1_vld_i  (s1_vld_i),
  .s1_cls_i  (s1_cls_i),
  .s1_wr_i   (s1_wr_i),
  .s1_dst_i  (s1_dst_i),
  .s1_srca_i (s1_srca_i),
  .s1_srcb_i (s1_srcb_i),
  .iss0_o    (iss0_o),
  .iss1_o    (iss1_o),
  .pipe0_o   (pipe0_o),
  .pipe1_o   (pipe1_o),
  .pend_w    (pend_w)
);

// File: tb/test_dual_issue_ctl.sv
module test_dual_issue_ctl;

  localparam int NREG = 16;
  localparam int FREE = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       v0 = 1'b0, w0 = 1'b0, v1 = 1'b0, w1 = 1'b0;
  logic [1:0] c0 = '0, c1 = '0;
  logic [3:0] d0 = '0, a0 = '0, b0 = '0, d1 = '0, a1 = '0, b1 = '0;
  logic       is0, is1;
  logic [1:0] p0, p1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;
  int ready_at [NREG];
  logic [31:0] seed = 32'h1d2c3b4a;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_issue_ctl i_dual_issue_ctl (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .s0_vld_i(v0), .s0_cls_i(c0), .s0_wr_i(w0), .s0_dst_i(d0), .s0_srca_i(a0), .s0_srcb_i(b0),
    .s1_vld_i(v1), .s1_cls_i(c1), .s1_wr_i(w1), .s1_dst_i(d1), .s1_srca_i(a1), .s1_srcb_i(b1),
    .iss0_o(is0), .iss1_o(is1), .pipe0_o(p0), .pipe1_o(p1)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lat(input logic [1:0] c);
    if (c == 2'd1) return 3;
    if (c == 2'd2) return 4;
    return 1;
  endfunction

  function automatic bit busy(input logic [3:0] r);
    return (int'(r) != FREE) && (cyc < ready_at[r]);
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // Drive one cycle, compare against the ready-time model, advance the model
  task automatic step(input bit f,
                      input bit vv0, input logic [1:0] cc0, input bit ww0,
                      input logic [3:0] dd0, input logic [3:0] aa0, input logic [3:0] bb0,
                      input bit vv1, input logic [1:0] cc1, input bit ww1,
                      input logic [3:0] dd1, input logic [3:0] aa1, input logic [3:0] bb1,
                      input string ctx);
    bit e0, e1, dep, clash, single0;
    string t0, t1;
    int now, ep0, ep1;
    @(negedge clk);
    flush = f;
    v0 = vv0; c0 = cc0; w0 = ww0; d0 = dd0; a0 = aa0; b0 = bb0;
    v1 = vv1; c1 = cc1; w1 = ww1; d1 = dd1; a1 = aa1; b1 = bb1;
    #2;
    now = cyc;
    e0 = 0; t0 = "R2";
    if (f) t0 = "R9";
    else if (!vv0) t0 = "R2";
    else if (busy(aa0) || busy(bb0)) t0 = "R3";
    else if (ww0 && busy(dd0)) t0 = "R4";
    else e0 = 1;
    dep = ww0 && (int'(dd0) != FREE) && (aa1 == dd0 || bb1 == dd0 || (ww1 && dd1 == dd0));
    single0 = (cc0 == 2'd1) || (cc0 == 2'd2);
    clash = single0 && (cc0 == cc1);
    e1 = 0; t1 = "R2";
    if (!e0) t1 = f ? "R9" : "R2";
    else if (!vv1) t1 = "R2";
    else if (dep) t1 = "R5";
    else if (clash) t1 = "R6";
    else if (busy(aa1) || busy(bb1)) t1 = "R3";
    else if (ww1 && busy(dd1)) t1 = "R4";
    else e1 = 1;
    ep0 = !e0 ? 0 : (cc0 == 2'd1) ? 2 : (cc0 == 2'd2) ? 3 : 0;
    ep1 = !e1 ? 0 : (cc1 == 2'd1) ? 2 : (cc1 == 2'd2) ? 3 : (single0 ? 0 : 1);
    check(t0, int'(is0), int'(e0), {ctx, " issue0"});
    check(t1, int'(is1), int'(e1), {ctx, " issue1"});
    check("R7", int'(p0), ep0, {ctx, " pipe0"});
    check("R7", int'(p1), ep1, {ctx, " pipe1"});
    if (f) begin
      foreach (ready_at[i]) ready_at[i] = 0;
    end else begin
      if (e0 && ww0 && int'(dd0) != FREE) ready_at[dd0] = now + lat(cc0);
      if (e1 && ww1 && int'(dd1) != FREE) ready_at[dd1] = now + lat(cc1);
    end
  endtask

  task automatic idle_flush(input string ctx);
    step(1, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, ctx);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog actual hung expected done");
      finish_run();
    end
  end

  initial begin
    foreach (ready_at[i]) ready_at[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: clean scoreboard after reset, every register readable
    for (int r = 0; r < NREG; r++) begin
      step(0, 1, 2'd0, 0, 4'(r), 4'(r), 4'(r), 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R1 reset");
      check("R1", int'(is0), 1, "issue after reset");
    end

    // R3 / R4: release distance per class, for a reader and for a rewriter
    for (int c = 0; c < 3; c++) begin
      for (int kind = 0; kind < 2; kind++) begin
        int n;
        idle_flush("R3 prep");
        step(0, 1, 2'(c), 1, 4'd1, 4'd15, 4'd15, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R3 producer");
        n = 0;
        for (int k = 1; k <= 8; k++) begin
          if (kind == 0)
            step(0, 1, 2'd0, 0, 4'd0, 4'd1, 4'd15, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R3 reader");
          else
            step(0, 1, 2'd0, 1, 4'd1, 4'd15, 4'd15, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R4 rewriter");
          if (is0 && n == 0) n = k;
          if (n != 0) break;
        end
        if (kind == 0) check("R3", n, lat(2'(c)), "reader release distance");
        else           check("R4", n, lat(2'(c)), "rewriter release distance");
      end
    end

    // R8: register 15 never pending, never a pair dependency
    idle_flush("R8 prep");
    step(0, 1, 2'd2, 1, 4'd15, 4'd0, 4'd0, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R8 write 15");
    step(0, 1, 2'd0, 0, 4'd0, 4'd15, 4'd15, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R8 read 15");
    check("R8", int'(is0), 1, "read of 15 after multiply");
    step(0, 1, 2'd1, 1, 4'd15, 4'd0, 4'd0, 1, 2'd0, 1, 4'd15, 4'd15, 4'd15, "R8 pair 15");
    check("R8", int'(is1), 1, "pair through 15");

    // R10: store sets nothing
    idle_flush("R10 prep");
    step(0, 1, 2'd1, 0, 4'd2, 4'd0, 4'd0, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R10 store");
    step(0, 1, 2'd0, 0, 4'd0, 4'd2, 4'd2, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R10 reader");
    check("R10", int'(is0), 1, "reader after store");

    // R9: flush blocks issue then clears pending
    step(0, 1, 2'd2, 1, 4'd3, 4'd0, 4'd0, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R9 producer");
    step(1, 1, 2'd0, 0, 4'd0, 4'd0, 4'd0, 1, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R9 flush");
    check("R9", int'(is0), 0, "issue during flush");
    step(0, 1, 2'd0, 0, 4'd0, 4'd3, 4'd3, 0, 2'd0, 0, 4'd0, 4'd0, 4'd0, "R9 after");
    check("R9", int'(is0), 1, "reader after flush");

    // R5 / R6 / R7: every class pair against every register relation
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        for (int rel = 0; rel < 5; rel++) begin
          logic [3:0] dd0, aa1, bb1, dd1;
          bit ww1;
          dd0 = 4'd1; aa1 = 4'd2; bb1 = 4'd2; dd1 = 4'd3; ww1 = 1;
          case (rel)
            1: aa1 = 4'd1;
            2: bb1 = 4'd1;
            3: dd1 = 4'd1;
            4: begin dd0 = 4'd15; aa1 = 4'd15; dd1 = 4'd15; end
            default: ;
          endcase
          idle_flush("sweep prep");
          step(0, 1, 2'(x), 1, dd0, 4'd0, 4'd0, 1, 2'(y), ww1, dd1, aa1, bb1, "R5 R6 sweep");
        end
      end
    end

    // Pseudo-random traffic over registers 0..3 and 15
    for (int t = 0; t < 3000; t++) begin
      logic [31:0] r1, r2;
      logic [3:0] rg [6];
      r1 = rnd();
      r2 = rnd();
      for (int i = 0; i < 6; i++) begin
        int m;
        m = int'((r2 >> (3 * i)) & 32'h7) % 5;
        rg[i] = (m == 4) ? 4'd15 : 4'(m);
      end
      step((r1[4:0] == 5'd0),
           (r1[7:5] != 3'd0), r1[9:8], r1[10], rg[0], rg[1], rg[2],
           (r1[13:11] != 3'd0), r1[15:14], r1[16], rg[3], rg[4], rg[5], "random");
    end

    finished = 1;
    finish_run();
  end

endmodule